// File: doc/BRIEF.md
# Compressed Byte/Halfword Instruction Expander

This block turns one 16-bit compressed instruction from the byte/halfword code-size subset into the 32-bit base instruction that does the same work. The subset has five forms that reach memory: unsigned byte load, signed and unsigned halfword loads, byte store and halfword store. It also has a register multiply and six single-register operations: byte and halfword sign-extension, byte, halfword and word zero-extension, and bitwise inversion. A decode stage places the expander in front of its normal 32-bit decoder. That decoder then sees only base encodings.

The input is decoded in one combinational step, and the result is captured in an output register. The 32-bit word and an illegal flag therefore appear one clock after the input is presented. The parameter `XLEN` (32 or 64) selects the target width. It changes the major opcode used for halfword zero-extension. It also decides whether word zero-extension is accepted. Any encoding outside the subset sets the illegal flag and gives an all-zero word.

Top module: `cbx_expander`

## Requirements
- R1: While `rst` is high at a rising edge, the next output is `xinstr_o` = 0 and `illegal_o` = 0.
- R2: The output produced by an input appears after the first rising clock edge that samples that input, and it holds until the next edge.
- R3: A 3-bit compressed register field r always names base register x(8+r). It is placed in the rd, rs1 and rs2 fields of the expanded word (bits 11:7, 19:15 and 24:20).
- R4: With bits[1:0]=00, function field bits[15:10]=100000 gives an unsigned byte load, and 100010 gives a byte store. The base register is in bits[9:7], and the data or destination register is in bits[4:2]. The offset is {bit5, bit6} (0..3), zero-extended to 12 bits.
- R5: With bits[1:0]=00 and bits[15:10]=100001, the block gives a halfword load. Bit 6 = 1 selects the signed load (funct3 001), and bit 6 = 0 selects the unsigned load (funct3 101). The offset is bit5 times 2.
- R6: With bits[1:0]=00 and bits[15:10]=100011, bit 6 = 0 gives a halfword store with offset bit5 times 2. Bit 6 = 1 is illegal.
- R7: With bits[1:0]=01, bits[15:10]=100111 and bits[6:5]=10, the block gives MUL rd,rd,rs2. Here rd is bits[9:7] and rs2 is bits[4:2].
- R8: In the same group, with bits[6:2]=11000, the block gives ANDI rd,rd,255. With bits[6:2]=11101 it gives XORI rd,rd,-1.
- R9: Code 11001 gives byte sign-extension (immediate word 0x604). Code 11011 gives halfword sign-extension (0x605). Code 11010 gives halfword zero-extension (0x080, funct3 100). Its major opcode is 0110011 when XLEN=32 and 0111011 when XLEN=64.
- R10: Code 11100 gives ADD.UW rd,rd,x0 when XLEN=64. It is illegal when XLEN=32.
- R11: Every other input is illegal: bits[1:0] of 10 or 11, unlisted function fields, bits[6:5] of 00 or 01 under 100111, and codes 11110 and 11111. In these cases `illegal_o` = 1 and `xinstr_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cinstr_i | input | 16 | Compressed instruction |
| xinstr_o | output | 32 | Registered expanded instruction |
| illegal_o | output | 1 | Registered illegal-encoding flag |

## Verification
The bench builds two copies, one with XLEN=64 and one with XLEN=32, and drives both with the same stimulus. The sweep covers all 65,536 input values. Every register pair, every offset and every reserved code is therefore checked against a separate arithmetic encoder in both width modes. Because both widths are built, the halfword zero-extension opcode difference and the width-dependent legality of word zero-extension are both within reach.

// File: rtl/cbx_pkg.sv
package cbx_pkg;
  localparam int CW = 16;
  localparam int XW = 32;

  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_REGW  = 7'b0111011;

  localparam logic [5:0] F6_LDB  = 6'b100000;
  localparam logic [5:0] F6_LDH  = 6'b100001;
  localparam logic [5:0] F6_STB  = 6'b100010;
  localparam logic [5:0] F6_STH  = 6'b100011;
  localparam logic [5:0] F6_ARITH = 6'b100111;

  // Compressed register field r names x(8+r)
  function automatic logic [4:0] creg(input logic [2:0] r);
    return {2'b01, r};
  endfunction

  function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                        input logic [2:0] f3, input logic [4:0] rd,
                                        input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [2:0] f3,
                                        input logic [6:0] op);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
  endfunction

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [2:0] f3,
                                        input logic [4:0] rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction
endpackage

// File: rtl/cbx_mem_decode.sv
module cbx_mem_decode
  import cbx_pkg::*;
(
  input  logic [CW-1:0] c,
  output logic          hit,
  output logic [XW-1:0] word
);
  logic [4:0]  base_r;
  logic [4:0]  data_r;
  logic [11:0] off_b;
  logic [11:0] off_h;
  logic        quad0;

  assign quad0  = (c[1:0] == 2'b00);
  assign base_r = creg(c[9:7]);
  assign data_r = creg(c[4:2]);
  assign off_b  = {10'd0, c[5], c[6]};
  assign off_h  = {10'd0, c[5], 1'b0};

  always_comb begin
    hit  = 1'b0;
    word = '0;
    if (quad0) begin
      unique case (c[15:10])
        F6_LDB: begin
          hit  = 1'b1;
          word = enc_i(off_b, base_r, 3'b100, data_r, OPC_LOAD);
        end
        F6_LDH: begin
          hit  = 1'b1;
          word = enc_i(off_h, base_r, c[6] ? 3'b001 : 3'b101, data_r, OPC_LOAD);
        end
        F6_STB: begin
          hit  = 1'b1;
          word = enc_s(off_b, data_r, base_r, 3'b000, OPC_STORE);
        end
        F6_STH: begin
          if (!c[6]) begin
            hit  = 1'b1;
            word = enc_s(off_h, data_r, base_r, 3'b001, OPC_STORE);
          end
        end
        default: begin
          hit  = 1'b0;
          word = '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/cbx_alu_decode.sv
module cbx_alu_decode
  import cbx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [CW-1:0] c,
  output logic          hit,
  output logic [XW-1:0] word
);
  logic [4:0] rd;
  logic [4:0] rs2;
  logic       grp;
  logic [6:0] zexth_op;
  logic       wext_ok;

  generate
    if (XLEN == 64) begin : g_rv64
      assign zexth_op = OPC_REGW;
      assign wext_ok  = 1'b1;
    end else begin : g_rv32
      assign zexth_op = OPC_REG;
      assign wext_ok  = 1'b0;
    end
  endgenerate

  assign grp = (c[1:0] == 2'b01) && (c[15:10] == F6_ARITH);
  assign rd  = creg(c[9:7]);
  assign rs2 = creg(c[4:2]);

  always_comb begin
    hit  = 1'b0;
    word = '0;
    if (grp) begin
      if (c[6:5] == 2'b10) begin
        hit  = 1'b1;
        word = enc_r(7'b0000001, rs2, rd, 3'b000, rd, OPC_REG);
      end else if (c[6:5] == 2'b11) begin
        unique case (c[4:2])
          3'b000: begin hit = 1'b1; word = enc_i(12'h0FF, rd, 3'b111, rd, OPC_IMM); end
          3'b001: begin hit = 1'b1; word = enc_i(12'h604, rd, 3'b001, rd, OPC_IMM); end
          3'b010: begin hit = 1'b1; word = enc_i(12'h080, rd, 3'b100, rd, zexth_op); end
          3'b011: begin hit = 1'b1; word = enc_i(12'h605, rd, 3'b001, rd, OPC_IMM); end
          3'b100: begin
            hit  = wext_ok;
            word = wext_ok ? enc_r(7'b0000100, 5'd0, rd, 3'b000, rd, OPC_REGW) : '0;
          end
          3'b101: begin hit = 1'b1; word = enc_i(12'hFFF, rd, 3'b100, rd, OPC_IMM); end
          default: begin hit = 1'b0; word = '0; end
        endcase
      end
    end
  end
endmodule

// File: rtl/cbx_out_reg.sv
module cbx_out_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_word,
  input  logic         d_bad,
  output logic [W-1:0] q_word,
  output logic         q_bad
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_word <= '0;
      q_bad  <= 1'b0;
    end else begin
      q_word <= d_word;
      q_bad  <= d_bad;
    end
  end
endmodule

// File: rtl/cbx_expander.sv
module cbx_expander
  import cbx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] cinstr_i,
  output logic [31:0] xinstr_o,
  output logic        illegal_o
);
  logic          mem_hit;
  logic          alu_hit;
  logic [XW-1:0] mem_word;
  logic [XW-1:0] alu_word;
  logic [XW-1:0] nxt_word;
  logic          nxt_bad;

  cbx_mem_decode u_mem (
    .c    (cinstr_i),
    .hit  (mem_hit),
    .word (mem_word)
  );

  cbx_alu_decode #(.XLEN(XLEN)) u_alu (
    .c    (cinstr_i),
    .hit  (alu_hit),
    .word (alu_word)
  );

  // The two decoders cover disjoint quadrants, so at most one hits
  always_comb begin
    nxt_bad  = !(mem_hit || alu_hit);
    nxt_word = mem_hit ? mem_word : (alu_hit ? alu_word : '0);
  end

  cbx_out_reg #(.W(XW)) u_oreg (
    .clk    (clk),
    .rst    (rst),
    .d_word (nxt_word),
    .d_bad  (nxt_bad),
    .q_word (xinstr_o),
    .q_bad  (illegal_o)
  );
endmodule

// File: rtl/cbx_expander_chk.sv
module cbx_expander_chk #(
  parameter int XLEN = 64
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] cinstr_i,
  input logic [31:0] xinstr_o,
  input logic        illegal_o
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  // R11: illegal output always carries an all-zero word
  p_zero_on_bad_r11: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (xinstr_o == 32'd0));

  // R11: quadrants 10 and 11 are never accepted
  p_quadrant_r11: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(cinstr_i[1])) |-> illegal_o);

  // R2: every accepted word is a full-length base encoding
  p_full_len_r2: assert property (@(posedge clk) disable iff (rst)
    (seen && !illegal_o) |-> (xinstr_o[1:0] == 2'b11));

  // R3: any destination field written lies in x8..x15
  p_rd_bank_r3: assert property (@(posedge clk) disable iff (rst)
    (seen && !illegal_o && xinstr_o[6:0] != 7'b0100011) |-> (xinstr_o[11:10] == 2'b01));

  generate
    if (XLEN == 32) begin : g_w32
      // R10: word zero-extension refused on the narrow target
      p_wext_bad_r10: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(cinstr_i[15:10]) == 6'b100111 && $past(cinstr_i[6:0]) == 7'b1110001)
        |-> illegal_o);
    end else begin : g_w64
      // R10: word zero-extension accepted on the wide target
      p_wext_ok_r10: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(cinstr_i[15:10]) == 6'b100111 && $past(cinstr_i[6:0]) == 7'b1110001)
        |-> (!illegal_o && xinstr_o[6:0] == 7'b0111011));
    end
  endgenerate
endmodule

bind cbx_expander cbx_expander_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cinstr_i  (cinstr_i),
  .xinstr_o  (xinstr_o),
  .illegal_o (illegal_o)
);

// File: tb/cbx_expander_test.sv
module cbx_expander_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cin = 16'd0;
  logic [31:0] w64, w32;
  logic        b64, b32;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbx_expander #(.XLEN(64)) uut (
    .clk(clk), .rst(rst), .cinstr_i(cin), .xinstr_o(w64), .illegal_o(b64));
  cbx_expander #(.XLEN(32)) uut32 (
    .clk(clk), .rst(rst), .cinstr_i(cin), .xinstr_o(w32), .illegal_o(b32));

  // Independent reference encoder
  task automatic ref_model(input logic [15:0] c, input bit rv64,
                           output logic [31:0] w, output bit bad, output string tag);
    logic [4:0] ra;
    logic [4:0] rb;
    ra  = 5'd8 + {2'b00, c[9:7]};
    rb  = 5'd8 + {2'b00, c[4:2]};
    w   = 32'd0;
    bad = 1'b0;
    tag = "R11";
    if (c[1:0] == 2'b00) begin
      case (c[15:10])
        6'h20: begin tag = "R4"; w = {10'd0, c[5], c[6], ra, 3'd4, rb, 7'h03}; end
        6'h21: begin tag = "R5"; w = {10'd0, c[5], 1'b0, ra, (c[6] ? 3'd1 : 3'd5), rb, 7'h03}; end
        6'h22: begin tag = "R4"; w = {7'd0, rb, ra, 3'd0, 3'd0, c[5], c[6], 7'h23}; end
        6'h23: begin
          tag = "R6";
          if (c[6]) bad = 1'b1;
          else w = {7'd0, rb, ra, 3'd1, 3'd0, c[5], 1'b0, 7'h23};
        end
        default: bad = 1'b1;
      endcase
    end else if (c[1:0] == 2'b01 && c[15:10] == 6'h27) begin
      if (c[6:5] == 2'b10) begin
        tag = "R7"; w = {7'h01, rb, ra, 3'd0, ra, 7'h33};
      end else if (c[6:5] == 2'b11) begin
        case (c[4:2])
          3'd0: begin tag = "R8"; w = {12'h0ff, ra, 3'd7, ra, 7'h13}; end
          3'd1: begin tag = "R9"; w = {12'h604, ra, 3'd1, ra, 7'h13}; end
          3'd2: begin tag = "R9"; w = {12'h080, ra, 3'd4, ra, (rv64 ? 7'h3b : 7'h33)}; end
          3'd3: begin tag = "R9"; w = {12'h605, ra, 3'd1, ra, 7'h13}; end
          3'd4: begin
            tag = "R10";
            if (rv64) w = {7'h04, 5'd0, ra, 3'd0, ra, 7'h3b};
            else bad = 1'b1;
          end
          3'd5: begin tag = "R8"; w = {12'hfff, ra, 3'd4, ra, 7'h13}; end
          default: bad = 1'b1;
        endcase
      end else bad = 1'b1;
    end else bad = 1'b1;
    if (bad) w = 32'd0;
  endtask

  task automatic check(input string tag, input string who, input logic [15:0] c,
                       input logic [31:0] got, input logic gotbad,
                       input logic [31:0] exp, input logic expbad);
    checks++;
    if (got !== exp || gotbad !== expbad) begin
      failures++;
      $display("FAIL %s %s in=%h got=%h/%0b exp=%h/%0b", tag, who, c, got, gotbad, exp, expbad);
    end
  endtask

  task automatic check_both(input logic [15:0] c);
    logic [31:0] e;
    bit eb;
    string t;
    ref_model(c, 1'b1, e, eb, t);
    check(t, "xlen64", c, w64, b64, e, eb);
    ref_model(c, 1'b0, e, eb, t);
    check(t, "xlen32", c, w32, b32, e, eb);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog expired got=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [15:0] prev;
    // R1: reset state with an illegal input present
    cin = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R1", "xlen64", cin, w64, b64, 32'd0, 1'b0);
    check("R1", "xlen32", cin, w32, b32, 32'd0, 1'b0);
    rst = 1'b0;

    // Full sweep, pipelined one input per cycle
    prev = 16'd0;
    for (int i = 0; i <= 65536; i++) begin
      @(negedge clk);
      if (i > 0) check_both(prev);
      if (i < 65536) begin
        cin  = i[15:0];
        prev = i[15:0];
      end
    end

    // R2: the output holds until the next edge, then updates
    @(negedge clk);
    cin = 16'h8000;
    #1;
    check("R2", "xlen64", cin, w64, b64, 32'd0, 1'b1);
    @(negedge clk);
    check("R2", "xlen64", cin, w64, b64, {12'd0, 5'd8, 3'd4, 5'd8, 7'h03}, 1'b0);

    // R3: highest compressed registers map to x15
    cin = {6'b100000, 3'd7, 2'b11, 3'd7, 2'b00};
    @(negedge clk);
    check("R3", "xlen64", cin, w64, b64, {10'd0, 2'b11, 5'd15, 3'd4, 5'd15, 7'h03}, 1'b0);

    // R1: reset again while a legal word is held
    rst = 1'b1;
    @(negedge clk);
    check("R1", "xlen32", cin, w32, b32, 32'd0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule